// File: doc/BRIEF.md
# Programmable External Bus Strobe Sequencer

This block produces the pin timing of one access to an external SRAM, ROM or I/O device that sits behind a single memory bank. The requester presents an address, a direction, a transfer size, write data and the bank's timing word, all in one cycle. The sequencer holds the address for the whole access. It places chip select, the read strobe (output enable) or the write strobes (active-low byte enables), and the write-data drive enable, each in its own cycle inside a programmable wait window. A hold phase may follow the window. On a read, the block captures the returned data. When the bus is released it pulses done.

The timing word sets how many cycles the data window lasts. It also sets whether chip select and each strobe start one cycle late, whether the strobe ends one cycle early, and how long the end state is held. On byte and halfword buses the two upper byte-enable pins are not needed as enables, so they carry the two lowest address bits. A timing word that cannot fit its strobes into the window still runs to completion, with the strobes clipped to the window, and raises an error output while the access lasts.

Top module: `ebus_strobe_seq`

## Requirements
- R1: A request (req high) is taken only when bus_busy is low. bus_busy rises in the next cycle, and bus_addr shows the request address for the whole access. A request raised while bus_busy is high is ignored: it starts no second access and changes neither the address nor the direction of the current one.
- R2: req_cfg bits [7:2] hold the wait count W and bits [14:12] hold the hold field H. An access keeps bus_busy high for W+1 window cycles (t = 0..W), followed by H-1 extra hold cycles when H > 1 and none otherwise. bus_done is high for exactly one cycle, in the first cycle after bus_busy falls.
- R3: If cs delay (req_cfg bit 8) is 1, bus_cs_n goes low at window cycle t = 1. If it is 0, bus_cs_n goes low at t = 0. It then stays low until the bus is released.
- R4: On a read, bus_oe_n is low in window cycles t with t >= cs_delay + rd_delay (rd_delay = req_cfg bit 9) and t + early_off <= W (early_off = req_cfg bit 11). It is high otherwise and on writes.
- R5: On a write, each enabled byte lane of bus_wbe_n is low in window cycles t with t >= cs_delay + wr_delay (wr_delay = req_cfg bit 10) and t + early_off <= W. Byte lanes are always high on reads.
- R6: During the hold cycles every bus output keeps the value it had in window cycle t = W.
- R7: When the bus width is 32 bits (req_cfg [1:0] = 10 or 11), byte lane i is enabled as follows. req_size 0 (byte) enables lane addr[1:0]. req_size 1 (halfword) enables lanes 2*addr[1] and 2*addr[1]+1. req_size 2 or 3 (word) enables all four lanes.
- R8: On a narrow bus (req_cfg [1:0] = 00 byte, 01 halfword), bus_wbe_n[2] carries addr[1] and bus_wbe_n[3] carries addr[0] during the access, and both are high when idle. A halfword bus enables lane addr[0] for byte transfers and lanes 0 and 1 otherwise. A byte bus enables lane 0 only.
- R9: On a write, bus_dout_en is high for the whole access including hold, and bus_dout shows req_wdata. On a read, bus_dout_en stays low.
- R10: On a read, bus_din is sampled at the end of window cycle t = W. The sampled value appears on rd_data from the bus_done cycle on, and data presented during hold cycles is not taken.
- R11: cfg_err is high throughout an access whose W is below cs_delay+wr_delay+early_off or below cs_delay+rd_delay+early_off, and low otherwise and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 32 | Write data |
| req_cfg | input | 15 | Bank timing word (fields in R2 to R8) |
| bus_din | input | 32 | Read data from the device |
| bus_busy | output | 1 | Address valid, access in progress |
| bus_addr | output | ADDR_W | Address pins |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable (read strobe), active low |
| bus_wbe_n | output | 4 | Byte write enables, active low; upper two carry address bits on narrow buses |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_dout | output | 32 | Write data pins |
| rd_data | output | 32 | Captured read data |
| bus_done | output | 1 | One-cycle end-of-access pulse |
| cfg_err | output | 1 | Timing word breaks the minimum-wait rule |

## Verification
The end-of-access pulse and the taking of a new request can fall in the same cycle, because bus_done is raised in the first idle cycle. The bench provokes this by driving a fresh request in exactly the cycle bus_done is seen. It expects bus_done high and bus_busy low in that cycle, then bus_busy high with the new address and bus_done low one cycle later. A stray request during the first cycle of every sweep access checks the opposite case: it must be dropped.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

    localparam int WAIT_W    = 6;
    localparam int HOLD_W    = 3;
    localparam int BUS_LANES = 4;
    localparam int DATA_W    = 8 * BUS_LANES;
    localparam int CFG_W     = HOLD_W + 4 + WAIT_W + 2;

    typedef enum logic [1:0] {
        BW_BYTE     = 2'b00,
        BW_HALF     = 2'b01,
        BW_WORD     = 2'b10,
        BW_WORD_ALT = 2'b11
    } bus_width_e;

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic              early_off;
        logic              wr_dly;
        logic              rd_dly;
        logic              cs_dly;
        logic [WAIT_W-1:0] wait_cnt;
        bus_width_e        width;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_WIN  = 2'b01,
        PH_HOLD = 2'b10
    } phase_e;

    function automatic logic [HOLD_W-1:0] extra_hold(logic [HOLD_W-1:0] h);
        return (h > HOLD_W'(1)) ? h - HOLD_W'(1) : '0;
    endfunction

    function automatic logic [BUS_LANES-1:0] lane_enables(bus_width_e w,
                                                          logic [1:0] sz,
                                                          logic [1:0] a);
        logic [BUS_LANES-1:0] m;
        case (w)
            BW_BYTE: m = 4'b0001;
            BW_HALF: m = (sz == 2'd0) ? (a[0] ? 4'b0010 : 4'b0001) : 4'b0011;
            default: begin
                case (sz)
                    2'd0:    m = 4'b0001 << a;
                    2'd1:    m = a[1] ? 4'b1100 : 4'b0011;
                    default: m = 4'b1111;
                endcase
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ebus_timing_ctl.sv
module ebus_timing_ctl
    import ebus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [WAIT_W-1:0] wait_q,
    input  logic [HOLD_W-1:0] hold_q,
    output logic              accept,
    output logic              busy,
    output logic              last_win,
    output logic              done,
    output logic [WAIT_W-1:0] tick
);

    phase_e            ph_q;
    logic [HOLD_W-1:0] h_q;

    assign accept   = (ph_q == PH_IDLE) && req;
    assign busy     = (ph_q != PH_IDLE);
    assign last_win = (ph_q == PH_WIN) && (tick == wait_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            h_q  <= '0;
            tick <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (req) begin
                        ph_q <= PH_WIN;
                        tick <= '0;
                    end
                end
                PH_WIN: begin
                    if (tick == wait_q) begin
                        if (extra_hold(hold_q) != '0) begin
                            ph_q <= PH_HOLD;
                            h_q  <= extra_hold(hold_q);
                        end else begin
                            ph_q <= PH_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_HOLD: begin
                    h_q <= h_q - 1'b1;
                    if (h_q == HOLD_W'(1)) begin
                        ph_q <= PH_IDLE;
                        done <= 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R2
    AST_TICK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tick <= wait_q));  // R2
    AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HOLD) |-> (tick == wait_q));  // R6

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
    import ebus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              is_wr,
    input  logic [WAIT_W-1:0] tick,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic              cs_dly,
    input  logic              rd_dly,
    input  logic              wr_dly,
    input  logic              early_off,
    output logic              cs_act,
    output logic              rd_strb,
    output logic              wr_strb,
    output logic              cfg_err
);

    logic [WAIT_W:0] t_ext, w_ext, cs_start, rd_start, wr_start, off_ext;
    logic            in_window;

    assign t_ext    = {1'b0, tick};
    assign w_ext    = {1'b0, wait_cnt};
    assign off_ext  = {{WAIT_W{1'b0}}, early_off};
    assign cs_start = {{WAIT_W{1'b0}}, cs_dly};
    assign rd_start = cs_start + {{WAIT_W{1'b0}}, rd_dly};
    assign wr_start = cs_start + {{WAIT_W{1'b0}}, wr_dly};

    assign in_window = (t_ext + off_ext) <= w_ext;

    assign cs_act  = busy && (t_ext >= cs_start);
    assign rd_strb = busy && !is_wr && (t_ext >= rd_start) && in_window;
    assign wr_strb = busy &&  is_wr && (t_ext >= wr_start) && in_window;
    assign cfg_err = busy && ((w_ext < wr_start + off_ext) ||
                              (w_ext < rd_start + off_ext));

    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        (rd_strb || wr_strb) |-> cs_act);  // R4
    AST_ONE_STROBE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(rd_strb && wr_strb));  // R5

endmodule

// File: rtl/ebus_lane_map.sv
module ebus_lane_map
    import ebus_seq_pkg::*;
(
    input  logic                 busy,
    input  logic                 wr_strb,
    input  bus_width_e           width,
    input  logic [1:0]           size,
    input  logic [1:0]           addr_lo,
    output logic [BUS_LANES-1:0] wbe_n
);

    logic                 narrow;
    logic [BUS_LANES-1:0] mask;

    assign narrow = (width == BW_BYTE) || (width == BW_HALF);
    assign mask   = lane_enables(width, size, addr_lo);

    for (genvar i = 0; i < BUS_LANES; i++) begin : g_lane
        if (i >= 2) begin : g_dual
            localparam int AB = BUS_LANES - 1 - i;
            assign wbe_n[i] = narrow ? (busy ? addr_lo[AB] : 1'b1)
                                     : !(wr_strb && mask[i]);
        end else begin : g_plain
            assign wbe_n[i] = !(wr_strb && mask[i]);
        end
    end

endmodule

// File: rtl/ebus_strobe_seq.sv
module ebus_strobe_seq
    import ebus_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_wr,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [CFG_W-1:0]     req_cfg,
    input  logic [DATA_W-1:0]    bus_din,
    output logic                 bus_busy,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_cs_n,
    output logic                 bus_oe_n,
    output logic [BUS_LANES-1:0] bus_wbe_n,
    output logic                 bus_dout_en,
    output logic [DATA_W-1:0]    bus_dout,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 bus_done,
    output logic                 cfg_err
);

    bank_cfg_t         cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_q;
    logic [1:0]        size_q;
    logic              wr_q;
    logic              accept, busy, last_win;
    logic [WAIT_W-1:0] tick;
    logic              cs_act, rd_strb, wr_strb;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= '0;
            wr_q    <= 1'b0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                cfg_q   <= bank_cfg_t'(req_cfg);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                size_q  <= req_size;
                wr_q    <= req_wr;
            end
            if (last_win && !wr_q) begin
                rd_q <= bus_din;
            end
        end
    end

    ebus_timing_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wait_q   (cfg_q.wait_cnt),
        .hold_q   (cfg_q.hold),
        .accept   (accept),
        .busy     (busy),
        .last_win (last_win),
        .done     (bus_done),
        .tick     (tick)
    );

    ebus_strobe_gen u_strobe (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .is_wr     (wr_q),
        .tick      (tick),
        .wait_cnt  (cfg_q.wait_cnt),
        .cs_dly    (cfg_q.cs_dly),
        .rd_dly    (cfg_q.rd_dly),
        .wr_dly    (cfg_q.wr_dly),
        .early_off (cfg_q.early_off),
        .cs_act    (cs_act),
        .rd_strb   (rd_strb),
        .wr_strb   (wr_strb),
        .cfg_err   (cfg_err)
    );

    ebus_lane_map u_lanes (
        .busy    (busy),
        .wr_strb (wr_strb),
        .width   (cfg_q.width),
        .size    (size_q),
        .addr_lo (addr_q[1:0]),
        .wbe_n   (bus_wbe_n)
    );

    assign bus_busy    = busy;
    assign bus_addr    = addr_q;
    assign bus_cs_n    = !cs_act;
    assign bus_oe_n    = !rd_strb;
    assign bus_dout_en = busy && wr_q;
    assign bus_dout    = wdata_q;
    assign rd_data     = rd_q;

    logic wide_bus;
    assign wide_bus = (cfg_q.width == BW_WORD) || (cfg_q.width == BW_WORD_ALT);

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        bus_busy |=> (!bus_busy || $stable(bus_addr)));  // R1
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && tick == cfg_q.wait_cnt) |=>
        (!bus_busy || ($stable(bus_cs_n) && $stable(bus_oe_n) && $stable(bus_wbe_n))));  // R6
    AST_READ_NO_LANES: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !bus_dout_en && wide_bus) |-> (bus_wbe_n == '1));  // R7
    AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        !(bus_dout_en && !bus_oe_n));  // R9
    AST_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> bus_busy);  // R11
    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> (bus_cs_n && bus_oe_n));  // R3

endmodule

// File: tb/test_ebus_strobe_seq.sv
`timescale 1ns/1ps
module test_ebus_strobe_seq;

    logic        clk = 1'b0;
    logic        rst, req, req_wr;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata, bus_din;
    logic [14:0] req_cfg;
    logic        bus_busy, bus_cs_n, bus_oe_n, bus_dout_en, bus_done, cfg_err;
    logic [31:0] bus_addr, bus_dout, rd_data;
    logic [3:0]  bus_wbe_n;

    int vectors = 0;
    int fails   = 0;

    int c_w, c_h, c_cs, c_ron, c_won, c_eo, c_wr, c_width, c_size;
    logic [31:0] c_addr, c_wdata;

    always #2 clk = ~clk;

    ebus_strobe_seq #(.ADDR_W(32)) i_ebus_strobe_seq (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cfg(req_cfg),
        .bus_din(bus_din), .bus_busy(bus_busy), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_wbe_n(bus_wbe_n),
        .bus_dout_en(bus_dout_en), .bus_dout(bus_dout), .rd_data(rd_data),
        .bus_done(bus_done), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int extra(int h);
        return (h > 1) ? h - 1 : 0;
    endfunction

    function automatic logic [3:0] exp_mask();
        logic [3:0] m;
        int nb, first;
        m = 4'b0000;
        if (c_width == 0) m[0] = 1'b1;
        else if (c_width == 1) begin
            if (c_size == 0) m[c_addr % 2] = 1'b1;
            else m = 4'b0011;
        end else begin
            nb = (c_size >= 2) ? 4 : (1 << c_size);
            first = ((c_addr % 4) / nb) * nb;
            for (int j = 0; j < nb; j++) m[first + j] = 1'b1;
        end
        return m;
    endfunction

    task automatic check_cycle(input int k);
        int tt;
        bit cs, rs, ws, err;
        logic [3:0] m, we;
        string sfx;
        tt  = (k > c_w) ? c_w : k;
        sfx = (k > c_w) ? " R6 hold" : "";
        cs  = (tt >= c_cs);
        rs  = (c_wr == 0) && (tt >= c_cs + c_ron) && (tt + c_eo <= c_w);
        ws  = (c_wr == 1) && (tt >= c_cs + c_won) && (tt + c_eo <= c_w);
        err = (c_w < c_cs + c_won + c_eo) || (c_w < c_cs + c_ron + c_eo);
        m   = exp_mask();
        for (int i = 0; i < 4; i++) we[i] = !(ws && m[i]);
        if (c_width < 2) begin
            we[2] = c_addr[1];
            we[3] = c_addr[0];
        end
        chk({"R1 busy", sfx}, 32'(bus_busy), 32'd1);
        chk({"R1 addr", sfx}, bus_addr, c_addr);
        chk({"R3 cs_n", sfx}, 32'(bus_cs_n), 32'(!cs));
        chk({"R4 oe_n", sfx}, 32'(bus_oe_n), 32'(!rs));
        chk({"R5/R7/R8 wbe_n", sfx}, 32'(bus_wbe_n), 32'(we));
        chk({"R9 dout_en", sfx}, 32'(bus_dout_en), 32'(c_wr));
        if (c_wr == 1) chk({"R9 dout", sfx}, bus_dout, c_wdata);
        chk({"R11 cfg_err", sfx}, 32'(cfg_err), 32'(err));
        chk({"R2 done low while busy", sfx}, 32'(bus_done), 32'd0);
    endtask

    task automatic drive_req();
        req       = 1'b1;
        req_wr    = 1'(c_wr);
        req_size  = 2'(c_size);
        req_addr  = c_addr;
        req_wdata = c_wdata;
        req_cfg   = {3'(c_h), 1'(c_eo), 1'(c_won), 1'(c_ron), 1'(c_cs), 6'(c_w), 2'(c_width)};
    endtask

    task automatic run_access(input bit stray);
        int total;
        @(negedge clk);
        drive_req();
        @(negedge clk);
        req = 1'b0;
        total = c_w + 1 + extra(c_h);
        for (int k = 0; k < total; k++) begin
            bus_din = 32'hC0DE_0000 | 32'(k);
            if (stray && k == 0 && total >= 2) begin
                req      = 1'b1;
                req_addr = ~c_addr;
                req_wr   = 1'(!c_wr);
            end
            if (k == 1) req = 1'b0;
            check_cycle(k);
            @(negedge clk);
        end
        req = 1'b0;
        chk("R2 done pulse", 32'(bus_done), 32'd1);
        chk("R2 busy released", 32'(bus_busy), 32'd0);
        chk("R3 cs_n released", 32'(bus_cs_n), 32'd1);
        chk("R9 dout_en released", 32'(bus_dout_en), 32'd0);
        chk("R11 cfg_err idle", 32'(cfg_err), 32'd0);
        if (c_width < 2) chk("R8 addr lanes idle", 32'(bus_wbe_n), 32'hF);
        if (c_wr == 0) chk("R10 rd_data", rd_data, 32'hC0DE_0000 | 32'(c_w));
    endtask

    task automatic after_idle();
        @(negedge clk);
        chk("R2 done one cycle", 32'(bus_done), 32'd0);
        chk("R1 stray request ignored", 32'(bus_busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=hung expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; req_wr = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0; req_cfg = '0; bus_din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R2 reset done", 32'(bus_done), 32'd0);
        chk("R1 reset busy", 32'(bus_busy), 32'd0);
        chk("R3 reset cs_n", 32'(bus_cs_n), 32'd1);
        chk("R4 reset oe_n", 32'(bus_oe_n), 32'd1);
        chk("R5 reset wbe_n", 32'(bus_wbe_n), 32'hF);
        chk("R9 reset dout_en", 32'(bus_dout_en), 32'd0);
        chk("R11 reset cfg_err", 32'(cfg_err), 32'd0);

        // timing sweep on a 32-bit bus, word transfers
        c_width = 2; c_size = 2;
        for (int w = 0; w <= 4; w++)
            for (int h = 0; h <= 3; h++)
                for (int f = 0; f < 16; f++)
                    for (int d = 0; d < 2; d++) begin
                        c_w = w; c_h = h; c_wr = d;
                        c_cs = f & 1; c_ron = (f >> 1) & 1;
                        c_won = (f >> 2) & 1; c_eo = (f >> 3) & 1;
                        c_addr  = 32'h1000_0000 + 32'(w * 256 + h * 64 + f * 4);
                        c_wdata = 32'hA500_0000 | 32'(w * 1000 + h * 100 + f * 2 + d);
                        run_access(1'b1);
                        after_idle();
                    end

        // lane sweep: every bus width, size and low address
        c_w = 2; c_h = 0; c_cs = 0; c_ron = 0; c_won = 0; c_eo = 0;
        for (int bw = 0; bw < 4; bw++)
            for (int sz = 0; sz < 3; sz++)
                for (int a = 0; a < 4; a++)
                    for (int d = 0; d < 2; d++) begin
                        c_width = bw; c_size = sz; c_wr = d;
                        c_addr  = 32'h2000_0010 | 32'(a);
                        c_wdata = 32'h5A5A_0000 | 32'(bw * 16 + sz * 4 + a);
                        run_access(1'b0);
                        after_idle();
                    end

        // request taken in the same cycle as the done pulse
        c_width = 2; c_size = 2; c_w = 1; c_h = 0; c_wr = 1;
        c_cs = 0; c_ron = 0; c_won = 0; c_eo = 0;
        c_addr = 32'h3000_0000; c_wdata = 32'h1234_5678;
        run_access(1'b0);
        c_addr = 32'h3000_0040; c_wr = 0;
        drive_req();
        @(negedge clk);
        req = 1'b0;
        chk("R1 back-to-back accepted", 32'(bus_busy), 32'd1);
        chk("R1 back-to-back addr", bus_addr, 32'h3000_0040);
        chk("R2 done after back-to-back", 32'(bus_done), 32'd0);
        chk("R9 back-to-back read drive", 32'(bus_dout_en), 32'd0);
        while (!bus_done) @(negedge clk);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule